// File: doc/BRIEF.md
# Secure Launch Sequencer

This block carries out a dynamic root-of-trust launch in hardware. When a launch request arrives with the base address of a secure loader image, the sequencer works through a fixed order of steps. It masks interrupts. It raises a DMA fence over the whole loader region. It pulses a reset strobe that forces the memory-control registers to safe values. It then reads the loader image byte by byte and forwards each byte to a trusted measurement module. Every forwarded byte carries a privileged locality tag that software-initiated bus cycles cannot produce.

Once the last byte has gone out, the sequencer waits for the trusted module to confirm that the measurement is recorded. It then issues a single jump pulse that carries the loader entry point. If no confirmation arrives within a programmable number of cycles, the sequencer locks into a failure state. In that state interrupts stay masked and the fence stays raised until the block is reset.

The image size is a power of two set by a parameter, 64 KB by default, and the base address must be aligned to that size. Memory is read through a single-channel valid/ready port. The read data is taken in the cycle the beat is accepted.

Top module: `secure_launch_seq`

## Requirements
- R1: An accepted launch request sets `irq_mask` one cycle later. In that cycle `fence_en` is still low and no memory read is presented, so interrupts are masked before anything else happens.
- R2: One cycle after the mask rises, `fence_en` rises with `fence_base` equal to the launch base and `fence_limit` equal to base + image size − 1. The fence stays up through the jump cycle, and every read address lies inside it.
- R3: `regs_reset` is a single-cycle pulse in the cycle after the fence rises, before the first memory read is presented.
- R4: The image is 2^IMG_LOG2 bytes (default 16, i.e. 64 KB). Reads are issued at ascending addresses from the base through base + size − 1. The address advances by one only on a beat where `mem_rd_en` and `mem_rd_rdy` are both high, and exactly one read is accepted per image byte.
- R5: Each accepted byte appears on `tm_data` with `tm_valid` high one cycle after its beat. `tm_last` marks the final byte. `tm_locality` is high exactly in the cycles where `tm_valid` is high and low in all others.
- R6: `tm_ack` has no effect while the image is still being streamed. No jump follows an acknowledgement given before the last byte.
- R7: An acknowledgement during the wait phase gives a one-cycle `jump_valid` pulse on the next cycle, with `jump_addr` equal to the launch base and `busy` low. In the following cycle `irq_mask` and `fence_en` fall.
- R8: A request whose base has any of the low IMG_LOG2 bits set gives a one-cycle `err_align` pulse on the next cycle and changes nothing else: `busy`, `irq_mask` and `fence_en` stay low, and no read is issued.
- R9: `busy` is high from the cycle after an accepted request until the jump or the failure. Requests that arrive while busy are ignored, and the fence base and jump address keep the original base.
- R10: If no acknowledgement arrives, `err_timeout` rises L cycles after the cycle that shows `tm_last`, where L is `tmo_limit`, or 1 when `tmo_limit` is 0. An acknowledgement in the wait cycles before that point is accepted. After a timeout, `err_timeout`, `irq_mask` and `fence_en` hold and new requests are ignored until reset.
- R11: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_req | input | 1 | Launch request, sampled while idle |
| launch_base | input | ADDR_W | Loader base address |
| tmo_limit | input | TMO_W | Acknowledge timeout in cycles, latched at launch |
| busy | output | 1 | Launch in progress |
| err_align | output | 1 | One-cycle pulse for a misaligned request |
| err_timeout | output | 1 | Sticky acknowledge timeout |
| irq_mask | output | 1 | Interrupts masked |
| regs_reset | output | 1 | Memory-control register reset strobe |
| fence_en | output | 1 | DMA fence active |
| fence_base | output | ADDR_W | Fence lower bound |
| fence_limit | output | ADDR_W | Fence upper bound, inclusive |
| mem_rd_en | output | 1 | Read request valid |
| mem_rd_addr | output | ADDR_W | Read byte address |
| mem_rd_rdy | input | 1 | Read accepted, data valid |
| mem_rd_data | input | 8 | Read data byte |
| tm_valid | output | 1 | Measurement byte valid |
| tm_data | output | 8 | Measurement byte |
| tm_last | output | 1 | Final image byte |
| tm_locality | output | 1 | Privileged locality tag |
| tm_ack | input | 1 | Measurement stored |
| jump_valid | output | 1 | Control transfer pulse |
| jump_addr | output | ADDR_W | Loader entry point |

## Verification
Launches are run at random aligned bases, and the read port's ready is thrown with densities from sparse to nearly constant. These runs separate correct ascending addressing and byte forwarding from off-by-one or stall-sensitive counting. A misaligned base, a second request during a launch, and an acknowledgement in mid-stream each check that an input is ignored. Acknowledgements at zero delay and at the last permitted wait cycle, and missing acknowledgements with a nonzero and a zero timeout, pin down the exact edge between jump and failure.

// File: rtl/secure_launch_seq.sv
module secure_launch_seq #(
  parameter int ADDR_W   = 32,
  parameter int IMG_LOG2 = 16,
  parameter int TMO_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_req,
  input  logic [ADDR_W-1:0] launch_base,
  input  logic [TMO_W-1:0]  tmo_limit,
  output logic              busy,
  output logic              err_align,
  output logic              err_timeout,
  output logic              irq_mask,
  output logic              regs_reset,
  output logic              fence_en,
  output logic [ADDR_W-1:0] fence_base,
  output logic [ADDR_W-1:0] fence_limit,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_rdy,
  input  logic [7:0]        mem_rd_data,
  output logic              tm_valid,
  output logic [7:0]        tm_data,
  output logic              tm_last,
  output logic              tm_locality,
  input  logic              tm_ack,
  output logic              jump_valid,
  output logic [ADDR_W-1:0] jump_addr
);

  localparam int PAGE_W = ADDR_W - IMG_LOG2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_MASK, ST_FENCE, ST_SCRUB, ST_STREAM, ST_WAIT, ST_JUMP, ST_FAIL
  } phase_t;

  phase_t              phase;
  logic [PAGE_W-1:0]   page_q;
  logic [IMG_LOG2-1:0] offs_q;
  logic [TMO_W-1:0]    tmo_q;
  logic [TMO_W-1:0]    wait_q;
  logic                misaligned;
  logic [TMO_W-1:0]    wait_max;

  assign misaligned = |launch_base[IMG_LOG2-1:0];
  assign wait_max   = (tmo_q == '0) ? '0 : tmo_q - TMO_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= ST_IDLE;
      page_q    <= '0;
      offs_q    <= '0;
      tmo_q     <= '0;
      wait_q    <= '0;
      err_align <= 1'b0;
      tm_valid  <= 1'b0;
      tm_data   <= '0;
      tm_last   <= 1'b0;
    end else begin
      err_align <= 1'b0;
      tm_valid  <= 1'b0;
      tm_last   <= 1'b0;
      unique case (phase)
        ST_IDLE: if (launch_req) begin
          if (misaligned) begin
            err_align <= 1'b1;
          end else begin
            page_q <= launch_base[ADDR_W-1:IMG_LOG2];
            tmo_q  <= tmo_limit;
            phase  <= ST_MASK;
          end
        end
        ST_MASK:  phase <= ST_FENCE;
        ST_FENCE: phase <= ST_SCRUB;
        ST_SCRUB: begin
          offs_q <= '0;
          phase  <= ST_STREAM;
        end
        ST_STREAM: if (mem_rd_rdy) begin
          tm_valid <= 1'b1;
          tm_data  <= mem_rd_data;
          offs_q   <= offs_q + 1'b1;
          if (&offs_q) begin
            tm_last <= 1'b1;
            wait_q  <= '0;
            phase   <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (tm_ack)                  phase  <= ST_JUMP;
          else if (wait_q == wait_max) phase  <= ST_FAIL;
          else                         wait_q <= wait_q + 1'b1;
        end
        ST_JUMP: phase <= ST_IDLE;
        ST_FAIL: phase <= ST_FAIL;
        default: phase <= ST_IDLE;
      endcase
    end
  end

  assign busy        = phase inside {ST_MASK, ST_FENCE, ST_SCRUB, ST_STREAM, ST_WAIT};
  assign irq_mask    = phase != ST_IDLE;
  assign fence_en    = phase inside {ST_FENCE, ST_SCRUB, ST_STREAM, ST_WAIT, ST_JUMP, ST_FAIL};
  assign regs_reset  = phase == ST_SCRUB;
  assign err_timeout = phase == ST_FAIL;
  assign fence_base  = {page_q, {IMG_LOG2{1'b0}}};
  assign fence_limit = {page_q, {IMG_LOG2{1'b1}}};
  assign mem_rd_en   = phase == ST_STREAM;
  assign mem_rd_addr = {page_q, offs_q};
  assign tm_locality = tm_valid;
  assign jump_valid  = phase == ST_JUMP;
  assign jump_addr   = fence_base;

  AST_MASK_BEFORE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> irq_mask && fence_en && !regs_reset); // R1
  AST_MASK_BEFORE_FENCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fence_en) |-> $past(irq_mask)); // R1
  AST_READ_IN_FENCE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> mem_rd_addr >= fence_base && mem_rd_addr <= fence_limit); // R2
  AST_SCRUB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    regs_reset |=> !regs_reset && mem_rd_en); // R3
  AST_LOCALITY_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
    tm_locality |-> fence_en && irq_mask && !regs_reset && !jump_valid); // R5
  AST_JUMP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    jump_valid |=> !jump_valid && !irq_mask && !fence_en); // R7
  AST_ALIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err_align |-> !busy && !irq_mask && !fence_en); // R8
  AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(fence_base)); // R9
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |=> err_timeout && irq_mask && fence_en && !busy); // R10

endmodule

// File: tb/secure_launch_seq_test.sv
`timescale 1ns/1ps
module secure_launch_seq_test;
  localparam int AW = 32;
  localparam int LG = 8;
  localparam int TW = 8;
  localparam int N  = 1 << LG;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, launch_req, mem_rd_rdy, tm_ack;
  logic [AW-1:0] launch_base;
  logic [TW-1:0] tmo_limit;
  logic          busy, err_align, err_timeout, irq_mask, regs_reset, fence_en;
  logic [AW-1:0] fence_base, fence_limit, mem_rd_addr, jump_addr;
  logic          mem_rd_en, tm_valid, tm_last, tm_locality, jump_valid;
  logic [7:0]    mem_rd_data, tm_data;

  secure_launch_seq #(.ADDR_W(AW), .IMG_LOG2(LG), .TMO_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .launch_req(launch_req), .launch_base(launch_base),
    .tmo_limit(tmo_limit), .busy(busy), .err_align(err_align), .err_timeout(err_timeout),
    .irq_mask(irq_mask), .regs_reset(regs_reset), .fence_en(fence_en),
    .fence_base(fence_base), .fence_limit(fence_limit), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_rdy(mem_rd_rdy), .mem_rd_data(mem_rd_data),
    .tm_valid(tm_valid), .tm_data(tm_data), .tm_last(tm_last), .tm_locality(tm_locality),
    .tm_ack(tm_ack), .jump_valid(jump_valid), .jump_addr(jump_addr));

  function automatic logic [7:0] img_byte(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {a[3:0], a[7:4]} ^ 8'h3C;
  endfunction

  assign mem_rd_data = img_byte(mem_rd_addr);

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;
  int rdy_pct = 100;
  logic [AW-1:0] cur_base;
  int rd_idx, tm_idx, jump_cnt;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin
    mem_rd_rdy = 1'b0;
    forever begin
      @(posedge clk);
      #1 mem_rd_rdy = ($urandom % 100) < rdy_pct;
    end
  end

  always @(negedge clk) begin
    if (mem_rd_en && mem_rd_rdy) begin
      chk(mem_rd_addr == cur_base + AW'(rd_idx), "R4 read address", mem_rd_addr, cur_base + AW'(rd_idx));
      rd_idx++;
    end
    if (tm_valid || tm_locality) begin
      chk(tm_valid && tm_locality, "R5 locality", {tm_locality, tm_valid}, 2'b11);
      chk(tm_data == img_byte(cur_base + AW'(tm_idx)), "R5 data", tm_data, img_byte(cur_base + AW'(tm_idx)));
      chk(tm_last == (tm_idx == N-1), "R5 last", tm_last, (tm_idx == N-1));
      tm_idx++;
    end
    if (jump_valid) jump_cnt++;
  end

  task automatic do_reset();
    rst_n = 1'b0; launch_req = 1'b0; tm_ack = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic do_launch(input logic [AW-1:0] base, input int tmo, input int delay,
                           input bit early_ack, input bit dup_req);
    int eff;
    int waited;
    eff = (tmo == 0) ? 1 : tmo;
    cur_base = base; rd_idx = 0; tm_idx = 0; jump_cnt = 0;
    @(negedge clk);
    launch_req = 1'b1; launch_base = base; tmo_limit = TW'(tmo);
    @(negedge clk);
    launch_req = 1'b0;
    chk(irq_mask && !fence_en && busy && !mem_rd_en, "R1 mask first",
        {irq_mask, fence_en, busy, mem_rd_en}, 4'b1010);
    @(negedge clk);
    chk(fence_en && fence_base == base && fence_limit == base + AW'(N-1) && !regs_reset,
        "R2 fence bounds", fence_limit, base + AW'(N-1));
    if (dup_req) begin
      launch_req = 1'b1;
      launch_base = base ^ (AW'(1) << (LG+1));
    end
    @(negedge clk);
    launch_req = 1'b0;
    chk(regs_reset && !mem_rd_en, "R3 reset strobe", {regs_reset, mem_rd_en}, 2'b10);
    @(negedge clk);
    chk(!regs_reset, "R3 single pulse", regs_reset, 1'b0);
    if (early_ack) begin
      while (rd_idx < N/2) @(negedge clk);
      tm_ack = 1'b1;
      @(negedge clk);
      tm_ack = 1'b0;
      chk(jump_cnt == 0 && busy, "R6 early ack ignored", jump_cnt, 0);
    end
    while (!(tm_valid && tm_last)) @(negedge clk);
    chk(rd_idx == N && !mem_rd_en, "R4 beat count", rd_idx, N);
    if (delay < eff) begin
      repeat (delay) @(negedge clk);
      tm_ack = 1'b1;
      @(negedge clk);
      tm_ack = 1'b0;
      chk(jump_valid && jump_addr == base && !busy, "R7 jump", jump_addr, base);
      chk(fence_base == base && jump_cnt == 0, "R9 base kept", fence_base, base);
      @(negedge clk);
      chk(!jump_valid && !irq_mask && !fence_en && !err_timeout, "R7 release",
          {jump_valid, irq_mask, fence_en, err_timeout}, 4'b0000);
      chk(tm_idx == N, "R5 byte count", tm_idx, N);
    end else begin
      waited = 0;
      do begin
        @(negedge clk);
        waited++;
      end while (!err_timeout && waited < 300);
      chk(waited == eff, "R10 timeout cycle", waited, eff);
      chk(irq_mask && fence_en && !busy && !jump_valid, "R10 hold",
          {irq_mask, fence_en, busy, jump_valid}, 4'b1100);
      launch_req = 1'b1; launch_base = base + AW'(N);
      @(negedge clk);
      launch_req = 1'b0;
      repeat (4) @(negedge clk);
      chk(err_timeout && !mem_rd_en && fence_base == base && irq_mask, "R10 sticky",
          fence_base, base);
      do_reset();
      @(negedge clk);
      chk(!err_timeout && !irq_mask && !fence_en, "R11 reset clears",
          {err_timeout, irq_mask, fence_en}, 3'b000);
    end
  endtask

  task automatic bad_req(input logic [AW-1:0] base);
    int seen;
    seen = rd_idx;
    @(negedge clk);
    launch_req = 1'b1; launch_base = base;
    @(negedge clk);
    launch_req = 1'b0;
    chk(err_align && !busy && !irq_mask && !fence_en, "R8 align pulse",
        {err_align, busy, irq_mask, fence_en}, 4'b1000);
    @(negedge clk);
    chk(!err_align && !busy && !irq_mask && !mem_rd_en && rd_idx == seen, "R8 no change",
        {err_align, busy, irq_mask, mem_rd_en}, 4'b0000);
  endtask

  task automatic finish_run();
    ended = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd1729));
    launch_base = '0; tmo_limit = '0; cur_base = '0;
    rd_idx = 0; tm_idx = 0; jump_cnt = 0;
    do_reset();
    @(negedge clk);
    chk({busy, err_align, err_timeout, irq_mask, regs_reset, fence_en, mem_rd_en,
         tm_valid, tm_locality, jump_valid} == '0, "R11 reset state",
        {busy, err_align, err_timeout, irq_mask, regs_reset, fence_en, mem_rd_en,
         tm_valid, tm_locality, jump_valid}, 0);

    bad_req(32'h0004_0081);
    bad_req(32'h0004_0180);
    rdy_pct = 100;
    do_launch(32'h0004_0000, 5, 0, 0, 1);
    rdy_pct = 40;
    do_launch(32'h8000_1200, 6, 5, 1, 0);
    rdy_pct = 10;
    do_launch(32'hFFFF_FF00, 1, 0, 0, 1);
    for (int i = 0; i < 6; i++) begin
      logic [AW-1:0] b;
      int t;
      b = $urandom;
      b[LG-1:0] = '0;
      t = 1 + ($urandom % 20);
      rdy_pct = 20 + ($urandom % 81);
      do_launch(b, t, $urandom % t, i[0], i[1]);
    end
    rdy_pct = 70;
    do_launch(32'h0010_0000, 4, 9, 0, 0);
    do_launch(32'h0020_0000, 0, 5, 1, 0);
    bad_req(32'h0030_0001);
    do_launch(32'h0030_0000, 3, 2, 0, 0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      checks++;
      fails++;
      $display("FAIL R7 watchdog: actual no completion expected completion");
      finish_run();
    end
  end
endmodule